// File: doc/BRIEF.md
# Quadrature Bus Clock Generator

This block takes one fast input clock and divides it by four to produce two bus-phase clocks, E and Q. Q leads E by one input-clock period, so the pair are in quadrature, and each bus cycle splits into four intervals that bus logic can act on. A two-bit phase counter steps through four states. Each output is decoded from that counter.

A memory-ready input lets slow devices stretch a bus cycle. Ready is looked at only in the interval where both E and Q are high. If ready is low there, the counter stays put and both outputs stay high. Each held input clock adds one wait state to the cycle. A one-clock strobe marks the last interval of every bus cycle, so bus logic can latch data or start the next access.

Top module: `bus_phase_clkgen`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the block goes to the idle interval, where `eOut`=0, `qOut`=0 and `cycleEnd`=0.
- R2: With `memReady` held high, the pair (`qOut`,`eOut`) repeats the pattern (0,0), (1,0), (1,1), (0,1), one step per input clock, so a bus cycle is four input clocks long.
- R3: Q leads E by one input clock. `eOut` rises only one clock after `qOut` rose. `eOut` falls only one clock after `qOut` fell.
- R4: When `memReady` is low at a clock edge in the interval where `qOut`=1 and `eOut`=1, the block stays in that interval, and both outputs stay high for that clock.
- R5: In the intervals (0,0), (1,0) and (0,1), `memReady` has no effect. The sequence advances as in R2.
- R6: `cycleEnd` is high for exactly the one input clock in which `eOut`=1 and `qOut`=0. The next interval is (0,0).
- R7: The number of input clocks from one `cycleEnd` pulse to the next equals four plus the number of wait clocks inserted by R4 in between.
- R8: A stall has no upper bound. The block holds the (1,1) interval for as many clocks as `memReady` stays low, then moves on to (0,1) on the first edge at which it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock, four per bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| memReady | input | 1 | Memory ready. Low stretches the bus cycle with wait states |
| eOut | output | 1 | Bus clock E, high in the second half of the bus cycle |
| qOut | output | 1 | Bus clock Q, leading E by one input clock |
| cycleEnd | output | 1 | One-clock strobe in the last interval of each bus cycle |

## Verification
The bench applies every 8-bit pattern of `memReady` over eight clocks, so a low ready reaches every interval of the cycle. It compares each output against a phase model computed in the bench. Two faults are the main target. One is a design that samples ready in the wrong interval: it would stall with Q low or E low, or ignore a low ready where it should wait. The other is a design that lets the outputs change during a stall: it would drop E before the memory is ready. The bench also measures bus-cycle lengths between end strobes and runs one long stall. A miscounted wrap shows up as a cycle of the wrong length or a missing strobe. A capped wait shows up as a stall that ends early. A reset in the middle of a cycle must return the outputs to the idle state.

// File: rtl/busphase_pkg.sv
package busphase_pkg;
  localparam int PHASE_W = 2;
  localparam int PHASE_COUNT = 1 << PHASE_W;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE  = 2'd0,
    PH_QRISE = 2'd1,
    PH_HOLD  = 2'd2,
    PH_EONLY = 2'd3
  } phase_e;

  typedef struct packed {
    logic clear;
    logic advance;
    logic wrap;
  } phase_strobe_t;
endpackage

// File: rtl/busphase_ctrl.sv
module busphase_ctrl
  import busphase_pkg::*;
(
  input  logic          rst,
  input  logic          memReady,
  input  phase_e        phase,
  output phase_strobe_t strobes
);
  logic stallNow;

  always_comb begin
    stallNow        = (phase == PH_HOLD) && !memReady;
    strobes.clear   = rst;
    strobes.advance = !rst && !stallNow;
    strobes.wrap    = !rst && (phase == PH_EONLY);
  end
endmodule

// File: rtl/busphase_datapath.sv
module busphase_datapath
  import busphase_pkg::*;
(
  input  logic          clk,
  input  phase_strobe_t strobes,
  output phase_e        phase,
  output logic          eOut,
  output logic          qOut,
  output logic          cycleEnd
);
  phase_e phaseNext;

  always_comb begin
    phaseNext = phase_e'(phase + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      phase <= PH_IDLE;
    end else if (strobes.advance) begin
      phase <= phaseNext;
    end
  end

  always_comb begin
    qOut     = (phase == PH_QRISE) || (phase == PH_HOLD);
    eOut     = (phase == PH_HOLD) || (phase == PH_EONLY);
    cycleEnd = strobes.wrap;
  end
endmodule

// File: rtl/bus_phase_clkgen.sv
module bus_phase_clkgen
  import busphase_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic memReady,
  output logic eOut,
  output logic qOut,
  output logic cycleEnd
);
  phase_e        phase;
  phase_strobe_t strobes;

  busphase_ctrl u_ctrl (
    .rst      (rst),
    .memReady (memReady),
    .phase    (phase),
    .strobes  (strobes)
  );

  busphase_datapath u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .phase    (phase),
    .eOut     (eOut),
    .qOut     (qOut),
    .cycleEnd (cycleEnd)
  );
endmodule

// File: rtl/bus_phase_clkgen_checker.sv
module bus_phase_clkgen_checker (
  input logic clk,
  input logic rst,
  input logic memReady,
  input logic eOut,
  input logic qOut,
  input logic cycleEnd
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!eOut && !qOut && !cycleEnd));

  assert_idle_to_qrise_R2: assert property (@(posedge clk) disable iff (rst)
    (!eOut && !qOut) |=> (qOut && !eOut));

  assert_e_rise_after_q_R3: assert property (@(posedge clk) disable iff (rst)
    (qOut && !eOut) |=> (qOut && eOut));

  assert_e_fall_after_q_R3: assert property (@(posedge clk) disable iff (rst)
    (eOut && !qOut) |=> (!eOut && !qOut));

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (eOut && qOut && !memReady) |=> (eOut && qOut));

  assert_release_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (eOut && qOut && memReady) |=> (eOut && !qOut));

  assert_end_interval_R6: assert property (@(posedge clk) disable iff (rst)
    (eOut && !qOut) |-> cycleEnd);

  assert_end_only_there_R6: assert property (@(posedge clk) disable iff (rst)
    cycleEnd |-> (eOut && !qOut));
endmodule

bind bus_phase_clkgen bus_phase_clkgen_checker u_checker (
  .clk      (clk),
  .rst      (rst),
  .memReady (memReady),
  .eOut     (eOut),
  .qOut     (qOut),
  .cycleEnd (cycleEnd)
);

// File: tb/tb_bus_phase_clkgen.sv
module tb_bus_phase_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic memReady = 1'b1;
  logic eOut, qOut, cycleEnd;

  int checks = 0;
  int errors = 0;
  int modelPhase = 0;
  bit lastHeld = 1'b0;
  bit prevE = 1'b0, prevQ = 1'b0;
  int sinceEnd = 0;
  int waitCount = 0;
  bit seenEnd = 1'b0;

  always #2 clk = ~clk;

  bus_phase_clkgen dut (
    .clk      (clk),
    .rst      (rst),
    .memReady (memReady),
    .eOut     (eOut),
    .qOut     (qOut),
    .cycleEnd (cycleEnd)
  );

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {q,e,end}=%b expected %b (phase %0d)", req, act, exp, modelPhase);
    end
  endtask

  task automatic compare(input bit readyUsed, input bit wasReset);
    logic [2:0] exp;
    string req;
    exp = {(modelPhase == 1 || modelPhase == 2), (modelPhase >= 2), (modelPhase == 3)};
    if (wasReset) req = "R1";
    else if (lastHeld) req = "R4";
    else if (!readyUsed) req = "R5";
    else req = "R2";
    check(req, {qOut, eOut, cycleEnd}, exp);
    check("R6", {1'b0, 1'b0, cycleEnd}, {1'b0, 1'b0, (eOut && !qOut)});
    if (!wasReset && eOut && !prevE) check("R3", {2'b0, prevQ}, 3'b001);
    if (!wasReset && !eOut && prevE) check("R3", {2'b0, prevQ}, 3'b000);
    if (wasReset) begin
      seenEnd = 1'b0; sinceEnd = 0; waitCount = 0;
    end else begin
      sinceEnd++;
      if (cycleEnd) begin
        if (seenEnd) check("R7", 3'(sinceEnd - waitCount), 3'd4);
        seenEnd = 1'b1; sinceEnd = 0; waitCount = 0;
      end
    end
    prevE = eOut; prevQ = qOut;
  endtask

  task automatic step(input bit rdy, input bit doReset);
    rst = doReset;
    memReady = rdy;
    @(posedge clk);
    #1;
    lastHeld = 1'b0;
    if (doReset) modelPhase = 0;
    else if (modelPhase == 2 && !rdy) begin
      lastHeld = 1'b1;
      waitCount++;
    end else modelPhase = (modelPhase + 1) % 4;
    @(negedge clk);
    compare(rdy, doReset);
  endtask

  initial begin
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int pat = 0; pat < 256; pat++) begin
      for (int i = 0; i < 8; i++) step(pat[i], 1'b0);
    end
    // R8: long stall, then release
    while (modelPhase != 2) step(1'b1, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    check("R8", {qOut, eOut, cycleEnd}, 3'b011);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    // R1: reset in the middle of a bus cycle
    while (modelPhase != 3) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R1", {qOut, eOut, cycleEnd}, 3'b000);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule